// File: doc/BRIEF.md
# Coprocessor Run Controller

This block lets a host processor govern a small attached compute core that has no trap or interrupt machinery of its own. Through a three-register window the host loads and reads the core's program counter, commands it to run, stop or execute a single instruction, and reads back a status word that says whether the core is active and, once it has halted, why it halted.

The core side signals three events: an instruction retired, a stop instruction was reached, or an illegal instruction was met. The core never traps. A fault simply halts the core and latches a reason code, and the host decides whether and from where to restart it. The program counter advances by a fixed instruction size on every retirement. It stays at the halting instruction when a stop or an illegal instruction ends the run.

Register map (word address on `host_addr`): 0 is the program counter (read/write, zero-extended on read), 1 is the command register (write-only, reads 0), 2 is the status register, and 3 reads 0. Command bits: bit 0 run, bit 1 stop, bit 2 single-step. Status bits: bit 0 active (running or stepping), bits 3:1 stop reason, bit 4 rejected-PC-write flag, bit 5 stepping.

Top module: `rc_run_ctrl`

## Requirements
- R1: After reset the core is halted (`core_run` low, status 0), the program counter equals `RESET_PC` (default 0), the stop reason is 0 and the rejected-write flag is clear.
- R2: A write to address 0 while the core is halted loads the program counter on that clock edge, and an address-0 read returns it.
- R3: A write to address 0 while the core is active leaves the program counter unchanged and sets status bit 4. The bit stays set until the host writes status (address 2) with bit 4 at 1.
- R4: A run command (command bit 0) while halted makes the core active on the next edge, drives `core_run` high, sets status bit 0 and clears the stop reason to 0.
- R5: Each cycle in which the core is active and `core_retire` is high, with no stop or illegal event, advances the program counter by `STEP` (default 4).
- R6: A stop-instruction event while the core is active halts it with reason code 1 and leaves the program counter unchanged.
- R7: An illegal-instruction event while the core is active halts it with reason code 2 and leaves the program counter unchanged. It takes priority over a stop-instruction event in the same cycle.
- R8: A host stop command (command bit 1) while the core is active halts it with reason code 0. A core stop or illegal event in the same cycle decides the reason instead. A retirement in that cycle still advances the program counter.
- R9: A single-step command (command bit 2) while halted makes the core active with status bit 5 set until exactly one instruction retires. The core then halts with reason code 3 and the program counter advanced by `STEP`.
- R10: While the core is halted, `core_retire`, `core_stop_insn` and `core_illegal` have no effect on the program counter, the status or `core_run`.
- R11: Within one command write, stop takes priority over run, and run over single-step. Run and single-step commands are ignored while the core is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data for `host_addr` (combinational) |
| core_run | output | 1 | Core may execute (running or stepping) |
| core_pc | output | PC_W | Current program counter |
| core_retire | input | 1 | Core retired one instruction this cycle |
| core_stop_insn | input | 1 | Core reached a stop instruction |
| core_illegal | input | 1 | Core met an illegal instruction |

## Verification
Every cycle, the assertions check the program counter: it holds while the core is halted and not loaded, and it moves by exactly `STEP` on a retirement. They also check that the rejected-write flag stays set, that an illegal event always halts the core with code 2, that a step ends after one retirement with code 3, and that core events never wake a halted core. The bench's scenarios are needed for the rest. The exhaustive sweep of all sixteen combinations of retire, stop, illegal and host stop shows the priority among the reasons. Separate sequences show that the flag clears through the status write, that a step waits through idle cycles, and how a command word with several bits set resolves.

// File: rtl/rc_pkg.sv
package rc_pkg;

  typedef enum logic [1:0] {
    ST_HALT = 2'd0,
    ST_RUN  = 2'd1,
    ST_STEP = 2'd2
  } rc_state_e;

  localparam logic [2:0] RSN_HOST  = 3'd0;
  localparam logic [2:0] RSN_STOPI = 3'd1;
  localparam logic [2:0] RSN_ILL   = 3'd2;
  localparam logic [2:0] RSN_STEP  = 3'd3;

  localparam logic [1:0] ADDR_PC   = 2'd0;
  localparam logic [1:0] ADDR_CMD  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int CMD_GO_BIT   = 0;
  localparam int CMD_HALT_BIT = 1;
  localparam int CMD_STEP_BIT = 2;

  localparam int ST_ACT_BIT  = 0;
  localparam int ST_RSN_LSB  = 1;
  localparam int ST_ERR_BIT  = 4;
  localparam int ST_STEP_BIT = 5;

  // Does an active core halt this cycle?
  function automatic logic halt_now(input logic ill, input logic stopi,
                                    input logic host, input logic step_done);
    return ill | stopi | host | step_done;
  endfunction

  // Reason code for a halt, core faults ahead of host request.
  function automatic logic [2:0] halt_code(input logic ill, input logic stopi,
                                           input logic host);
    if (ill)        return RSN_ILL;
    else if (stopi) return RSN_STOPI;
    else if (host)  return RSN_HOST;
    else            return RSN_STEP;
  endfunction

endpackage

// File: rtl/rc_host_if.sv
module rc_host_if #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 16
) (
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [PC_W-1:0]   pc_q,
  input  logic              active,
  input  logic              stepping,
  input  logic [2:0]        reason,
  input  logic              wr_err,
  output logic              pc_wr,
  output logic [PC_W-1:0]   pc_wdata,
  output logic              cmd_go,
  output logic              cmd_halt,
  output logic              cmd_step,
  output logic              err_clr,
  output logic [DATA_W-1:0] host_rdata
);
  import rc_pkg::*;

  logic cmd_wr;
  logic stat_wr;

  assign cmd_wr   = host_wr && (host_addr == ADDR_CMD);
  assign stat_wr  = host_wr && (host_addr == ADDR_STAT);
  assign pc_wr    = host_wr && (host_addr == ADDR_PC);
  assign pc_wdata = host_wdata[PC_W-1:0];

  assign cmd_halt = cmd_wr && host_wdata[CMD_HALT_BIT];
  assign cmd_go   = cmd_wr && host_wdata[CMD_GO_BIT] && !host_wdata[CMD_HALT_BIT];
  assign cmd_step = cmd_wr && host_wdata[CMD_STEP_BIT] &&
                    !host_wdata[CMD_GO_BIT] && !host_wdata[CMD_HALT_BIT];
  assign err_clr  = stat_wr && host_wdata[ST_ERR_BIT];

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      ADDR_PC:   host_rdata[PC_W-1:0] = pc_q;
      ADDR_STAT: begin
        host_rdata[ST_ACT_BIT]              = active;
        host_rdata[ST_RSN_LSB+2:ST_RSN_LSB] = reason;
        host_rdata[ST_ERR_BIT]              = wr_err;
        host_rdata[ST_STEP_BIT]             = stepping;
      end
      default:   host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rc_seq.sv
module rc_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_go,
  input  logic       cmd_halt,
  input  logic       cmd_step,
  input  logic       evt_retire,
  input  logic       evt_stopi,
  input  logic       evt_ill,
  output logic       active,
  output logic       stepping,
  output logic [2:0] reason,
  output logic       pc_adv,
  output logic       halt_evt
);
  import rc_pkg::*;

  rc_state_e  state_q, state_d;
  logic [2:0] reason_q, reason_d;
  logic       step_done;

  assign active    = (state_q != ST_HALT);
  assign stepping  = (state_q == ST_STEP);
  assign reason    = reason_q;
  assign step_done = stepping && evt_retire;
  assign halt_evt  = active && halt_now(evt_ill, evt_stopi, cmd_halt, step_done);
  assign pc_adv    = active && evt_retire && !evt_ill && !evt_stopi;

  always_comb begin
    state_d  = state_q;
    reason_d = reason_q;
    if (active) begin
      if (halt_evt) begin
        state_d  = ST_HALT;
        reason_d = halt_code(evt_ill, evt_stopi, cmd_halt);
      end
    end else if (!cmd_halt) begin
      if (cmd_go) begin
        state_d  = ST_RUN;
        reason_d = RSN_HOST;
      end else if (cmd_step) begin
        state_d  = ST_STEP;
        reason_d = RSN_HOST;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_HALT;
      reason_q <= RSN_HOST;
    end else begin
      state_q  <= state_d;
      reason_q <= reason_d;
    end
  end

endmodule

// File: rtl/rc_pc.sv
module rc_pc #(
  parameter int          PC_W     = 16,
  parameter int          STEP     = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_wr,
  input  logic [PC_W-1:0] pc_wdata,
  input  logic            active,
  input  logic            pc_adv,
  input  logic            err_clr,
  output logic [PC_W-1:0] pc_q,
  output logic            pc_load,
  output logic            pc_reject,
  output logic            wr_err
);

  localparam logic [PC_W-1:0] STEP_INC = PC_W'(STEP);

  function automatic logic [PC_W-1:0] next_pc(input logic [PC_W-1:0] pc);
    return pc + STEP_INC;
  endfunction

  logic [PC_W-1:0] pc_r;
  logic            err_r;

  assign pc_load   = pc_wr && !active;
  assign pc_reject = pc_wr && active;
  assign pc_q      = pc_r;
  assign wr_err    = err_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_r <= RESET_PC;
    end else if (pc_load) begin
      pc_r <= pc_wdata;
    end else if (pc_adv) begin
      pc_r <= next_pc(pc_r);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          err_r <= 1'b0;
    else if (pc_reject)  err_r <= 1'b1;
    else if (err_clr)    err_r <= 1'b0;
  end

endmodule

// File: rtl/rc_run_ctrl.sv
module rc_run_ctrl #(
  parameter int              DATA_W   = 32,
  parameter int              PC_W     = 16,
  parameter int              STEP     = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              core_run,
  output logic [PC_W-1:0]   core_pc,
  input  logic              core_retire,
  input  logic              core_stop_insn,
  input  logic              core_illegal
);

  logic            pc_wr, cmd_go, cmd_halt, cmd_step, err_clr;
  logic [PC_W-1:0] pc_wdata, pc_q;
  logic            active, stepping, pc_adv, halt_evt;
  logic            pc_load, pc_reject, wr_err;
  logic [2:0]      reason;

  rc_host_if #(.DATA_W(DATA_W), .PC_W(PC_W)) host_i (
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .pc_q(pc_q), .active(active), .stepping(stepping), .reason(reason),
    .wr_err(wr_err), .pc_wr(pc_wr), .pc_wdata(pc_wdata), .cmd_go(cmd_go),
    .cmd_halt(cmd_halt), .cmd_step(cmd_step), .err_clr(err_clr),
    .host_rdata(host_rdata)
  );

  rc_seq seq_i (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_halt(cmd_halt),
    .cmd_step(cmd_step), .evt_retire(core_retire), .evt_stopi(core_stop_insn),
    .evt_ill(core_illegal), .active(active), .stepping(stepping),
    .reason(reason), .pc_adv(pc_adv), .halt_evt(halt_evt)
  );

  rc_pc #(.PC_W(PC_W), .STEP(STEP), .RESET_PC(RESET_PC)) pc_i (
    .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wdata(pc_wdata),
    .active(active), .pc_adv(pc_adv), .err_clr(err_clr), .pc_q(pc_q),
    .pc_load(pc_load), .pc_reject(pc_reject), .wr_err(wr_err)
  );

  assign core_run = active;
  assign core_pc  = pc_q;

endmodule

// File: rtl/rc_run_ctrl_chk.sv
module rc_run_ctrl_chk #(
  parameter int PC_W = 16,
  parameter int STEP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] pc_q,
  input logic            active,
  input logic            stepping,
  input logic [2:0]      reason,
  input logic            pc_load,
  input logic            pc_adv,
  input logic            wr_err,
  input logic            err_clr,
  input logic            cmd_go,
  input logic            cmd_step,
  input logic            core_retire,
  input logic            core_stop_insn,
  input logic            core_illegal
);

  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !pc_load) |=> $stable(pc_q));

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !err_clr) |=> wr_err);

  p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_adv |=> (pc_q == PC_W'($past(pc_q) + PC_W'(STEP))));

  p_illegal_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && core_illegal) |=> (!active && reason == 3'd2));

  p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && core_retire && !core_illegal && !core_stop_insn)
      |=> (!active && reason == 3'd3));

  p_halted_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cmd_go && !cmd_step) |=> !active);

endmodule

bind rc_run_ctrl rc_run_ctrl_chk #(.PC_W(PC_W), .STEP(STEP)) chk_i (
  .clk(clk), .rst_n(rst_n), .pc_q(pc_q), .active(active),
  .stepping(stepping), .reason(reason), .pc_load(pc_load), .pc_adv(pc_adv),
  .wr_err(wr_err), .err_clr(err_clr), .cmd_go(cmd_go), .cmd_step(cmd_step),
  .core_retire(core_retire), .core_stop_insn(core_stop_insn),
  .core_illegal(core_illegal)
);

// File: tb/rc_run_ctrl_tb.sv
module rc_run_ctrl_tb_top;

  localparam int DATA_W = 32;
  localparam int PC_W   = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_wr = 1'b0;
  logic [1:0]        host_addr = 2'd0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic [DATA_W-1:0] host_rdata;
  logic              core_run;
  logic [PC_W-1:0]   core_pc;
  logic              core_retire = 1'b0;
  logic              core_stop_insn = 1'b0;
  logic              core_illegal = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  rc_run_ctrl #(.DATA_W(DATA_W), .PC_W(PC_W), .STEP(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .core_run(core_run),
    .core_pc(core_pc), .core_retire(core_retire),
    .core_stop_insn(core_stop_insn), .core_illegal(core_illegal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  // one cycle of core events, optionally with a host stop command
  task automatic core_evt(input logic r, input logic s, input logic i, input logic h);
    @(negedge clk);
    core_retire = r; core_stop_insn = s; core_illegal = i;
    if (h) begin host_wr = 1'b1; host_addr = 2'd1; host_wdata = 32'h2; end
    @(negedge clk);
    core_retire = 1'b0; core_stop_insn = 1'b0; core_illegal = 1'b0;
    host_wr = 1'b0; host_wdata = '0;
  endtask

  function automatic logic [31:0] stat(input logic act, input logic [2:0] rsn,
                                       input logic err, input logic stp);
    return {26'd0, stp, err, rsn, act};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hread(2'd0, rd); check("R1 pc", rd, 32'h0);
    hread(2'd2, rd); check("R1 status", rd, 32'h0);
    check("R1 core_run", {31'd0, core_run}, 32'h0);

    // R2 load sweep while halted
    for (int k = 0; k < 16; k++) begin
      base = 16'(k * 16'h1357 + k);
      hwrite(2'd0, {16'd0, base});
      hread(2'd0, rd); check("R2 pc readback", rd, {16'd0, base});
      check("R2 core_pc", {16'd0, core_pc}, {16'd0, base});
    end

    // R4 run
    hwrite(2'd0, 32'h0040);
    hwrite(2'd1, 32'h1);
    hread(2'd2, rd); check("R4 status running", rd, stat(1, 0, 0, 0));
    check("R4 core_run", {31'd0, core_run}, 32'h1);

    // R5 retire sweep
    for (int n = 1; n <= 5; n++) begin
      core_evt(1, 0, 0, 0);
      check("R5 pc advance", {16'd0, core_pc}, 32'h40 + 32'(4 * n));
    end

    // R3 write while active rejected
    hwrite(2'd0, 32'h9999);
    hread(2'd0, rd); check("R3 pc unchanged", rd, 32'h54);
    hread(2'd2, rd); check("R3 err set", rd, stat(1, 0, 1, 0));
    core_evt(0, 0, 0, 1);
    hread(2'd2, rd); check("R3 err sticky after stop", rd, stat(0, 0, 1, 0));
    hwrite(2'd2, 32'h0);
    hread(2'd2, rd); check("R3 err kept without bit4", rd, stat(0, 0, 1, 0));
    hwrite(2'd2, 32'h10);
    hread(2'd2, rd); check("R3 err cleared", rd, stat(0, 0, 0, 0));

    // R6 R7 R8 exhaustive event combinations while running
    for (int c = 0; c < 16; c++) begin
      logic r, s, i, h, halts;
      logic [2:0] rsn;
      logic [15:0] epc;
      r = c[0]; s = c[1]; i = c[2]; h = c[3];
      hwrite(2'd0, 32'h100);
      hwrite(2'd1, 32'h1);
      core_evt(r, s, i, h);
      halts = i | s | h;
      rsn = i ? 3'd2 : (s ? 3'd1 : 3'd0);
      epc = 16'h100 + ((r && !i && !s) ? 16'd4 : 16'd0);
      hread(2'd2, rd);
      if (i)      check("R7 illegal reason", rd, stat(0, rsn, 0, 0));
      else if (s) check("R6 stop insn reason", rd, stat(0, rsn, 0, 0));
      else if (h) check("R8 host stop reason", rd, stat(0, rsn, 0, 0));
      else        check("R5 still running", rd, stat(1, 0, 0, 0));
      check("R8 pc after event", {16'd0, core_pc}, {16'd0, epc});
      if (!halts) core_evt(0, 0, 0, 1);
    end

    // R10 events ignored while halted (last reason 1 from c=15? illegal -> 2)
    hwrite(2'd0, 32'h300);
    for (int c = 0; c < 8; c++) begin
      core_evt(c[0], c[1], c[2], 0);
      hread(2'd2, rd); check("R10 status unchanged", rd, stat(0, 3'd2, 0, 0));
      check("R10 pc unchanged", {16'd0, core_pc}, 32'h300);
      check("R10 core_run low", {31'd0, core_run}, 32'h0);
    end

    // R9 single step
    hwrite(2'd0, 32'h200);
    for (int n = 1; n <= 3; n++) begin
      hwrite(2'd1, 32'h4);
      hread(2'd2, rd); check("R9 stepping", rd, stat(1, 0, 0, 1));
      core_evt(0, 0, 0, 0);
      hread(2'd2, rd); check("R9 waits for retire", rd, stat(1, 0, 0, 1));
      core_evt(1, 0, 0, 0);
      hread(2'd2, rd); check("R9 step done", rd, stat(0, 3'd3, 0, 0));
      check("R9 pc", {16'd0, core_pc}, 32'h200 + 32'(4 * n));
    end

    // R11 command priority
    hwrite(2'd1, 32'h7);
    hread(2'd2, rd); check("R11 stop beats all", rd, stat(0, 3'd3, 0, 0));
    hwrite(2'd1, 32'h6);
    hread(2'd2, rd); check("R11 stop beats step", rd, stat(0, 3'd3, 0, 0));
    hwrite(2'd1, 32'h5);
    hread(2'd2, rd); check("R11 run beats step", rd, stat(1, 0, 0, 0));
    hwrite(2'd1, 32'h4);
    hread(2'd2, rd); check("R11 step ignored while active", rd, stat(1, 0, 0, 0));
    core_evt(1, 0, 0, 0);
    hread(2'd2, rd); check("R11 still running after retire", rd, stat(1, 0, 0, 0));
    hwrite(2'd1, 32'h2);
    hread(2'd2, rd); check("R8 final stop", rd, stat(0, 0, 0, 0));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule